// File: doc/BRIEF.md
# Strap-addressed SMBus configuration register slave

This block is a two-wire serial slave that gives a host read and write access to a small bank of 8-bit configuration registers. It runs on a fast system clock and oversamples the SCL and SDA lines through synchronizer flops. From the sampled lines it finds START and STOP conditions, shifts bits in on rising SCL, and checks the first byte of each transfer against its own 7-bit address. That address is a fixed base, 0x58 by default, plus the value on four strap pins. The slave only pulls SDA low, through an open-drain enable output, and it changes that enable only while SCL is low.

A write carries one pointer byte after the address. Each later byte goes to the register the pointer selects, and the pointer then steps by one. A read re-addresses the slave after a repeated START. The slave then shifts out the selected register MSB first and moves to the next register each time the host ACKs. The bank has read/write registers with fixed reset values and read-only registers that show an input vector. A separate timer flags the bus as idle once both lines have stayed high long enough after a STOP, or long enough with no STOP seen. An enable input takes the slave off the bus altogether.

Top module: `smb_strap_slave`

## Requirements
- R1: The slave address is 0x58 plus the 4-bit `strap` value, so the address byte (address in bits 7:1, R/W in bit 0, 0 = write) runs from 0xB0 with strap 0 up to 0xCE with strap 15. A matching address byte is ACKed by holding SDA low for the ninth clock.
- R2: When an address byte does not match, it is NACKed. `sda_oe` then stays low and no register changes until the next START.
- R3: While `slave_en` is low, `sda_oe` is low in the same cycle, and no bus traffic changes any register.
- R4: A falling SDA edge while SCL is high is a START. A rising SDA edge while SCL is high is a STOP. Data bits are taken on rising SCL. A STOP in the middle of a byte drops that byte without writing it.
- R5: In a write, the first byte after the address is the register pointer. Each later byte is ACKed, written to the register the pointer selects, and then the pointer steps by one.
- R6: After a repeated START with R/W = 1, the slave shifts out the selected register MSB first and then the following registers for as long as the host ACKs. After the host NACKs, `sda_oe` stays low.
- R7: After reset, read/write register i (0 to NRW-1) holds 0x5A XOR (17*i mod 256), and `cfg_out[8i+7:8i]` shows register i.
- R8: Indices NRW to NRW+NRO-1 are read-only and read back `ro_in[8j+7:8j]` for j = index-NRW. Writes to them, or to any higher index, are ACKed and discarded. Reads above the bank return 0x00.
- R9: `sda_oe` rises only while the synchronized SCL is low. During an SCL-high period it changes only to release after a START or STOP.
- R10: `bus_idle` goes high once SCL and SDA have both been high for TBUF_CYC cycles after a STOP.
- R11: With no STOP seen, `bus_idle` goes high after THIGH_CYC cycles with both lines high. Any low level on either line clears it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_en | input | 1 | Enables slave mode; when low the bus is ignored |
| strap | input | 4 | Address offset added to the base address |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| bus_idle | output | 1 | Bus-free indication from the timeout logic |
| ro_in | input | NRO*8 | Values shown by the read-only registers |
| cfg_out | output | NRW*8 | Current contents of the read/write registers |

## Verification
On every cycle, the assertions check that `sda_oe` is forced low while the slave is disabled or ignoring a foreign address. They check that it only starts driving while SCL is low and holds steady through each SCL-high period. They also check that any low bus level clears `bus_idle`. The bench scenarios are needed for the protocol content: address matching for several strap values, pointer loading and auto-increment, MSB-first read data across ACK and NACK, discarding writes to read-only registers, aborting a byte with STOP, and the two idle timeouts.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_RACK, PH_IGN
  } phase_e;

  // slave address = base + strap offset
  function automatic logic [6:0] slave_addr(logic [6:0] base, logic [3:0] offs);
    return base + 7'(offs);
  endfunction

  // reset value of read/write register i
  function automatic logic [7:0] reg_default(int i);
    return 8'h5A ^ 8'(i * 17);
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int TBUF_CYC  = 24,
  parameter int THIGH_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic start_evt,
  input  logic stop_evt,
  output logic bus_idle
);
  localparam int CW = $clog2(THIGH_CYC + 2);
  localparam logic [CW-1:0] TBUF_L  = CW'(TBUF_CYC);
  localparam logic [CW-1:0] THIGH_L = CW'(THIGH_CYC);

  logic [CW-1:0] hi_cnt;
  logic          stop_seen;
  logic          both_high;

  assign both_high = scl_s & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      stop_seen <= 1'b0;
      bus_idle  <= 1'b0;
    end else begin
      if (!both_high)           hi_cnt <= '0;
      else if (hi_cnt < THIGH_L) hi_cnt <= hi_cnt + 1'b1;
      if (stop_evt)       stop_seen <= 1'b1;
      else if (start_evt) stop_seen <= 1'b0;
      bus_idle <= both_high && ((stop_seen && hi_cnt >= TBUF_L) || hi_cnt >= THIGH_L);
    end
  end

  // any low line level ends the idle indication
  p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !both_high |=> !bus_idle);
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NRW = 6,
  parameter int NRO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_idx,
  output logic [7:0]       rd_data,
  input  logic [NRO*8-1:0] ro_in,
  output logic [NRW*8-1:0] cfg_out
);
  import smb_pkg::*;

  for (genvar i = 0; i < NRW; i++) begin : g_rw
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          r <= reg_default(i);
      else if (wr_en && wr_idx == 8'(i))   r <= wr_data;
    end
    assign cfg_out[8*i +: 8] = r;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NRW; i++)
      if (rd_idx == 8'(i)) rd_data = cfg_out[8*i +: 8];
    for (int j = 0; j < NRO; j++)
      if (rd_idx == 8'(NRW + j)) rd_data = ro_in[8*j +: 8];
  end
endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave #(
  parameter logic [6:0] BASE_ADDR   = 7'h58,
  parameter int         NRW         = 6,
  parameter int         NRO         = 2,
  parameter int         TBUF_CYC    = 24,
  parameter int         THIGH_CYC   = 120,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic [3:0]       strap,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic             bus_idle,
  input  logic [NRO*8-1:0] ro_in,
  output logic [NRW*8-1:0] cfg_out
);
  import smb_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [6:0] my_addr;
  phase_e     phase;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh, tx_sh, ptr, rd_data;
  logic       addr_byte, want_ptr, rw_q, nack_q, drv;
  logic       byte_done, wr_en;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  smb_idle_timer #(.TBUF_CYC(TBUF_CYC), .THIGH_CYC(THIGH_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .bus_idle(bus_idle));

  smb_regbank #(.NRW(NRW), .NRO(NRO)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(rx_sh),
    .rd_idx(ptr), .rd_data(rd_data), .ro_in(ro_in), .cfg_out(cfg_out));

  assign my_addr   = slave_addr(BASE_ADDR, strap);
  assign byte_done = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
  assign wr_en     = slave_en && byte_done && !addr_byte && !want_ptr;
  assign sda_oe    = drv & slave_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      addr_byte <= 1'b0;
      want_ptr  <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      drv       <= 1'b0;
    end else if (!slave_en) begin
      phase <= PH_IDLE;
      drv   <= 1'b0;
    end else if (start_evt) begin
      phase     <= PH_RX;
      bitcnt    <= '0;
      addr_byte <= 1'b1;
      drv       <= 1'b0;
    end else if (stop_evt) begin
      phase <= PH_IDLE;
      drv   <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            rx_sh  <= {rx_sh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            if (addr_byte) begin
              addr_byte <= 1'b0;
              if (rx_sh[7:1] == my_addr) begin
                drv      <= 1'b1;
                phase    <= PH_ACK;
                rw_q     <= rx_sh[0];
                want_ptr <= ~rx_sh[0];
              end else begin
                phase <= PH_IGN;
              end
            end else begin
              drv   <= 1'b1;
              phase <= PH_ACK;
              if (want_ptr) begin
                ptr      <= rx_sh;
                want_ptr <= 1'b0;
              end else begin
                ptr <= ptr + 8'd1;
              end
            end
          end
        end
        PH_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw_q) begin
            phase <= PH_TX;
            tx_sh <= rd_data;
            drv   <= ~rd_data[7];
            ptr   <= ptr + 8'd1;
          end else begin
            phase <= PH_RX;
            drv   <= 1'b0;
          end
        end
        PH_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drv    <= 1'b0;
              phase  <= PH_RACK;
              bitcnt <= '0;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              drv   <= ~tx_sh[6];
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
            bitcnt <= 4'd1;
          end else if (scl_fall && bitcnt == 4'd1) begin
            bitcnt <= '0;
            if (nack_q) phase <= PH_IGN;
            else begin
              phase <= PH_TX;
              tx_sh <= rd_data;
              drv   <= ~rd_data[7];
              ptr   <= ptr + 8'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3: disabled slave never pulls SDA
  p_en_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |-> !sda_oe);

  // R2: ignoring a foreign address or a NACKed read leaves SDA alone
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !sda_oe);

  // R9: drive begins only while SCL is low
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9: output holds through SCL high except for a START/STOP release
  p_hold_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && $stable(slave_en) && !$past(start_evt) && !$past(stop_evt))
      |-> $stable(sda_oe));
endmodule

// File: tb/smb_strap_slave_tb.sv
module smb_strap_slave_tb;
  localparam int NRW = 6;
  localparam int NRO = 2;
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_en = 1'b1;
  logic [3:0] strap = 4'd0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe, bus_idle, sda_line;
  logic [NRO*8-1:0] ro_in = 16'h96A5;
  logic [NRW*8-1:0] cfg_out;

  assign sda_line = sda_h & ~sda_oe;

  smb_strap_slave u_dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .strap(strap),
    .scl_in(scl_h), .sda_in(sda_line), .sda_oe(sda_oe), .bus_idle(bus_idle),
    .ro_in(ro_in), .cfg_out(cfg_out));

  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0, oe_cnt = 0;
  bit done = 0;
  logic [7:0] mdl [NRW];
  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [7:0] obs_v[$];

  always @(posedge clk) if (sda_oe) oe_cnt++;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk);
    while (exp_v.size() > 0 && obs_v.size() > 0) begin
      automatic logic [7:0] e = exp_v.pop_front();
      automatic string      t = exp_tag.pop_front();
      automatic logic [7:0] o = obs_v.pop_front();
      chk(t, o, e);
    end
  end

  task automatic expect_item(logic [7:0] v, string tag);
    exp_v.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic hwait(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1; hwait(2); scl_h = 1; hwait(Q); sda_h = 0; hwait(Q); scl_h = 0; hwait(2);
  endtask
  task automatic bus_stop();
    sda_h = 0; hwait(2); scl_h = 1; hwait(Q); sda_h = 1; hwait(Q);
  endtask
  task automatic put_bit(logic b);
    sda_h = b; hwait(Q); scl_h = 1; hwait(Q); scl_h = 0; hwait(2);
  endtask
  task automatic get_bit(output logic b);
    sda_h = 1; hwait(Q); scl_h = 1; hwait(Q/2); b = sda_line; hwait(Q/2); scl_h = 0; hwait(2);
  endtask

  // sends a byte, queues the observed ACK (1 = acked)
  task automatic wr_byte(logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    obs_v.push_back({7'd0, ~b});
  endtask
  task automatic rd_byte(logic ack_it);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack_it);
    obs_v.push_back(v);
  endtask

  task automatic chk_cfg(string tag);
    for (int i = 0; i < NRW; i++) chk(tag, int'(cfg_out[8*i +: 8]), int'(mdl[i]));
  endtask

  initial begin
    for (int i = 0; i < NRW; i++) mdl[i] = 8'h5A ^ 8'((i << 4) + i);
    hwait(4); rst_n = 1;
    hwait(2);
    // R7 reset state
    chk("R7 reset sda_oe", int'(sda_oe), 0);
    chk("R11 reset idle", int'(bus_idle), 0);
    chk_cfg("R7 reset defaults");
    hwait(40);
    chk("R11 idle not yet", int'(bus_idle), 0);
    hwait(120);
    chk("R11 idle after max high", int'(bus_idle), 1);

    // R1/R5 write two registers with strap 0 (address byte 0xB0)
    bus_start();
    chk("R11 start clears idle", int'(bus_idle), 0);
    expect_item(1, "R1 ack 0xB0"); wr_byte(8'hB0);
    expect_item(1, "R5 ack ptr");  wr_byte(8'h01);
    expect_item(1, "R5 ack d1");   wr_byte(8'hC3); mdl[1] = 8'hC3;
    expect_item(1, "R5 ack d2");   wr_byte(8'h3C); mdl[2] = 8'h3C;
    bus_stop();
    chk_cfg("R5 auto-increment write");
    chk("R10 idle early", int'(bus_idle), 0);
    hwait(40);
    chk("R10 idle after bus-free", int'(bus_idle), 1);

    // R6 read three registers from pointer 0
    bus_start();
    expect_item(1, "R6 ack addr w"); wr_byte(8'hB0);
    expect_item(1, "R6 ack ptr");    wr_byte(8'h00);
    bus_start();
    expect_item(1, "R6 ack addr r"); wr_byte(8'hB1);
    expect_item(mdl[0], "R6 rd0"); rd_byte(1);
    expect_item(mdl[1], "R6 rd1"); rd_byte(1);
    expect_item(mdl[2], "R6 rd2"); rd_byte(0);
    hwait(4);
    chk("R6 released after NACK", int'(sda_oe), 0);
    bus_stop();

    // R8 read-only and out-of-range
    bus_start();
    expect_item(1, "R8 ack addr"); wr_byte(8'hB0);
    expect_item(1, "R8 ack ptr");  wr_byte(8'h06);
    expect_item(1, "R8 ack ro wr"); wr_byte(8'h11);
    expect_item(1, "R8 ack ro wr2"); wr_byte(8'h22);
    bus_start();
    expect_item(1, "R8 ack addr w2"); wr_byte(8'hB0);
    expect_item(1, "R8 ack ptr2");    wr_byte(8'h06);
    bus_start();
    expect_item(1, "R8 ack addr r"); wr_byte(8'hB1);
    expect_item(8'hA5, "R8 ro6"); rd_byte(1);
    expect_item(8'h96, "R8 ro7"); rd_byte(1);
    expect_item(8'h00, "R8 beyond"); rd_byte(0);
    bus_stop();
    chk_cfg("R8 rw untouched");

    // R2 foreign address
    begin
      automatic int c0 = oe_cnt;
      bus_start();
      expect_item(0, "R2 nack 0xB2"); wr_byte(8'hB2);
      expect_item(0, "R2 nack data"); wr_byte(8'h00);
      expect_item(0, "R2 nack data2"); wr_byte(8'hFF);
      bus_stop();
      chk("R2 sda_oe never set", oe_cnt - c0, 0);
      chk_cfg("R2 regs unchanged");
    end

    // R1 strap 5 -> 0xBA, strap 15 -> 0xCE
    strap = 4'd5; hwait(4);
    bus_start();
    expect_item(0, "R1 nack old addr"); wr_byte(8'hB0);
    bus_stop();
    bus_start();
    expect_item(1, "R1 ack 0xBA"); wr_byte(8'hBA);
    expect_item(1, "R1 ack ptr");  wr_byte(8'h03);
    expect_item(1, "R1 ack data"); wr_byte(8'h77); mdl[3] = 8'h77;
    bus_stop();
    chk_cfg("R1 strap 5 write");
    strap = 4'd15; hwait(4);
    bus_start();
    expect_item(1, "R1 ack 0xCE"); wr_byte(8'hCE);
    bus_stop();
    strap = 4'd0; hwait(4);

    // R3 disabled
    slave_en = 0; hwait(4);
    begin
      automatic int c0 = oe_cnt;
      bus_start();
      expect_item(0, "R3 nack disabled"); wr_byte(8'hB0);
      expect_item(0, "R3 nack ptr");      wr_byte(8'h00);
      expect_item(0, "R3 nack data");     wr_byte(8'hEE);
      bus_stop();
      chk("R3 sda_oe never set", oe_cnt - c0, 0);
      chk_cfg("R3 regs unchanged");
    end
    slave_en = 1; hwait(4);

    // R4 STOP in mid-byte discards the byte
    bus_start();
    expect_item(1, "R4 ack addr"); wr_byte(8'hB0);
    expect_item(1, "R4 ack ptr");  wr_byte(8'h04);
    expect_item(1, "R4 ack data"); wr_byte(8'h99); mdl[4] = 8'h99;
    put_bit(1); put_bit(0); put_bit(1);
    bus_stop();
    chk_cfg("R4 partial byte dropped");

    hwait(40);
    chk("R4 scoreboard drained", exp_v.size() + obs_v.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule